// File: doc/BRIEF.md
# Auto-Reloading Step Pulse Timer

This block generates the step clock for one stepper motor axis. A 16-bit counter runs on a timer tick derived from the system clock by a programmable divider. When the counter reaches its terminal value the step output drops for exactly one tick and a one-cycle terminal-count strobe is raised for an interrupt controller. At the end of that pulse the counter reloads itself from a shadow period register. Software therefore writes the period of the *next* step while the current one is still running. If it writes nothing, the last period repeats, which gives a constant slew rate with no host activity.

The host programs the block with an 8-bit command word, a 16-bit period (shadow) value, a level-sensitive global run input and a one-cycle software load strobe. The command word selects the counting direction, the output polarity, a pause, and whether the reload is taken from the end of the block's own pulse or from a rising edge on an external reload pin.

Top module: `step_pulse_timer`

## Requirements
- R1: After reset the counter and the shadow register are zero, the command word is all zeros (disabled, counting down, internal reload, active-low pulse), `step_out` is 1 and `tc_pulse` is 0.
- R2: While running and not paused, a tick occurs once every `tick_div`+1 clock cycles. The divider restarts from zero whenever the block is idle or paused. The counter value changes only on a tick or on a load.
- R3: In down mode (command bit 1 = 0), after a load of value N the counter decrements by one on each tick. It reaches zero and expires on the next tick, and reloads on the tick after that, so the reloads are N+2 ticks apart.
- R4: The pulse lasts exactly one tick. With command bit 3 = 0, `step_out` idles high and is low during the pulse. With bit 3 = 1 the levels are swapped.
- R5: Each expiry raises `tc_pulse` for exactly one clock cycle, in the same cycle in which the pulse starts.
- R6: With the internal reload source (command bit 5 = 0), the end of each pulse copies the shadow value into the counter. An unchanged shadow value repeats the same period.
- R7: A shadow write made in the same cycle as a reload does not reach that reload. The reload takes the previous shadow value, and the new value is used at the next expiry.
- R8: A `sw_load` strobe copies the shadow value into the counter at the next edge and ends any pulse in progress. This works whether or not the block is running.
- R9: While `run` is 0 or the enable bit (command bit 7) is 0, the counter holds, `step_out` shows its inactive level and `tc_pulse` stays 0.
- R10: With the pause bit (command bit 6) set, no ticks occur. The counter and the output level hold until the bit is cleared.
- R11: In up mode (command bit 1 = 1), the counter increments on each tick and expires at 16'hFFFF.
- R12: With the pin reload source (command bit 5 = 1), the counter parks at its terminal value after the pulse and produces no further expiry. A rising edge on `reload_pin` while running loads the shadow value and ends any pulse.
- R13: A command write with any of bits 0, 2 or 4 set is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 8 | Command word: bit 7 enable, bit 6 pause, bit 5 pin reload, bit 3 polarity, bit 1 count up |
| image_we | input | 1 | Shadow period write strobe |
| image_wdata | input | 16 | Shadow period value |
| run | input | 1 | Global start level |
| sw_load | input | 1 | Copy shadow value into counter |
| tick_div | input | 8 | Prescaler divisor minus one |
| reload_pin | input | 1 | External reload request (rising edge) |
| step_out | output | 1 | Step pulse output |
| tc_pulse | output | 1 | One-cycle terminal-count strobe |
| count_val | output | 16 | Current counter value |

## Verification
A wrong counter or divider state shows on `count_val` at the next tick, and it shifts the next `tc_pulse` and `step_out` edge by whole tick periods. A stale or early shadow capture shows only at the reload edge, so the reload cycle is targeted directly with a shadow write. A stuck pulse or parked flag shows as a missing or extra terminal-count strobe within one period. The bench's behavioural model compares all three outputs on every cycle, so any of these errors is reported in the cycle it first reaches a port.

// File: rtl/stp_pkg.sv
package stp_pkg;

    localparam int CMD_W = 8;

    typedef struct packed {
        logic en;
        logic pause;
        logic src_pin;
        logic pol;
        logic up;
    } stp_cmd_t;

    // Bits 0, 2 and 4 are reserved; a word using them is refused.
    function automatic logic cmd_legal(input logic [CMD_W-1:0] w);
        return (w[4] | w[2] | w[0]) == 1'b0;
    endfunction

    function automatic stp_cmd_t cmd_decode(input logic [CMD_W-1:0] w);
        stp_cmd_t c;
        c.en      = w[7];
        c.pause   = w[6];
        c.src_pin = w[5];
        c.pol     = w[3];
        c.up      = w[1];
        return c;
    endfunction

endpackage

// File: rtl/stp_prescaler.sv
module stp_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d   = st_q;
        wrap   = (st_q.pre >= div_i);
        tick_o = en_i && wrap;
        if (!en_i) begin
            st_d.pre = '0;
        end else if (wrap) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/stp_regs.sv
module stp_regs
    import stp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we_i,
    input  logic [CMD_W-1:0] cmd_wdata_i,
    input  logic             image_we_i,
    input  logic [CNT_W-1:0] image_wdata_i,
    input  logic             pin_i,
    output stp_cmd_t         cmd_o,
    output logic [CNT_W-1:0] image_o,
    output logic             pin_rise_o
);

    typedef struct packed {
        stp_cmd_t         cmd;
        logic [CNT_W-1:0] image;
        logic             pin;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pin = pin_i;
        if (cmd_we_i && cmd_legal(cmd_wdata_i)) begin
            st_d.cmd = cmd_decode(cmd_wdata_i);
        end
        if (image_we_i) begin
            st_d.image = image_wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_o      = st_q.cmd;
    assign image_o    = st_q.image;
    assign pin_rise_o = pin_i && !st_q.pin;

    // R13
    reserved_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_i && !cmd_legal(cmd_wdata_i)) |=> $stable(st_q.cmd));

endmodule

// File: rtl/stp_counter_core.sv
module stp_counter_core
    import stp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  stp_cmd_t         cmd_i,
    input  logic [CNT_W-1:0] image_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pulse_o,
    output logic             tc_o
);

    localparam logic [CNT_W-1:0] TERM_UP = '1;
    localparam logic [CNT_W-1:0] TERM_DN = '0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
        logic             parked;
        logic             tc;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [CNT_W-1:0] term;

    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;
        term    = cmd_i.up ? TERM_UP : TERM_DN;
        if (load_i) begin
            st_d.cnt    = image_i;
            st_d.pulse  = 1'b0;
            st_d.parked = 1'b0;
        end else if (!active_i) begin
            st_d.pulse = 1'b0;
        end else if (tick_i) begin
            if (st_q.pulse) begin
                st_d.pulse = 1'b0;
                if (cmd_i.src_pin) begin
                    st_d.parked = 1'b1;
                end else begin
                    st_d.cnt = image_i;
                end
            end else if (!st_q.parked) begin
                if (st_q.cnt == term) begin
                    st_d.pulse = 1'b1;
                    st_d.tc    = 1'b1;
                end else if (cmd_i.up) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o   = st_q.cnt;
    assign pulse_o = st_q.pulse;
    assign tc_o    = st_q.tc;

    // R5
    tc_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tc |-> st_q.pulse);

    // R4
    pulse_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pulse && tick_i && !load_i) |=> !st_q.pulse);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !load_i) |=> ($stable(st_q.cnt) && !st_q.tc && !st_q.pulse));

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(st_q.cnt));

    // R12
    parked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.parked && !load_i) |=> ($stable(st_q.cnt) && !st_q.tc));

endmodule

// File: rtl/step_pulse_timer.sv
module step_pulse_timer
    import stp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_wdata,
    input  logic             image_we,
    input  logic [CNT_W-1:0] image_wdata,
    input  logic             run,
    input  logic             sw_load,
    input  logic [PRE_W-1:0] tick_div,
    input  logic             reload_pin,
    output logic             step_out,
    output logic             tc_pulse,
    output logic [CNT_W-1:0] count_val
);

    stp_cmd_t         cmd;
    logic [CNT_W-1:0] image;
    logic             pin_rise;
    logic             active;
    logic             tick;
    logic             load;
    logic             pulse;

    stp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we_i     (cmd_we),
        .cmd_wdata_i  (cmd_wdata),
        .image_we_i   (image_we),
        .image_wdata_i(image_wdata),
        .pin_i        (reload_pin),
        .cmd_o        (cmd),
        .image_o      (image),
        .pin_rise_o   (pin_rise)
    );

    assign active = run && cmd.en;
    assign load   = sw_load || (active && cmd.src_pin && pin_rise);

    stp_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (active && !cmd.pause),
        .div_i (tick_div),
        .tick_o(tick)
    );

    stp_counter_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_i(active),
        .tick_i  (tick),
        .load_i  (load),
        .cmd_i   (cmd),
        .image_i (image),
        .cnt_o   (count_val),
        .pulse_o (pulse),
        .tc_o    (tc_pulse)
    );

    assign step_out = cmd.pol ? pulse : !pulse;

    // R10
    pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cmd.pause && !load) |-> !tick);

endmodule

// File: tb/step_pulse_timer_test.sv
module step_pulse_timer_test;

    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_we = 0;
    logic [7:0]  cmd_wdata = 0;
    logic        image_we = 0;
    logic [15:0] image_wdata = 0;
    logic        run = 0;
    logic        sw_load = 0;
    logic [7:0]  tick_div = 0;
    logic        reload_pin = 0;
    logic        step_out;
    logic        tc_pulse;
    logic [15:0] count_val;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";

    step_pulse_timer uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .image_we(image_we), .image_wdata(image_wdata), .run(run),
        .sw_load(sw_load), .tick_div(tick_div), .reload_pin(reload_pin),
        .step_out(step_out), .tc_pulse(tc_pulse), .count_val(count_val)
    );

    always #(CLK_P/2) clk = ~clk;

    // Behavioural reference: plain integers following the requirement text.
    int m_cnt = 0, m_img = 0, m_pre = 0;
    bit m_pulse = 0, m_park = 0, m_tc = 0, m_pin = 0;
    bit m_en = 0, m_pause = 0, m_src = 0, m_pol = 0, m_up = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_img = 0; m_pre = 0; m_pulse = 0; m_park = 0; m_tc = 0;
            m_pin = 0; m_en = 0; m_pause = 0; m_src = 0; m_pol = 0; m_up = 0;
        end else begin
            bit act, tk, ld;
            act = run && m_en;
            tk  = act && !m_pause && (m_pre >= tick_div);
            m_pre = (act && !m_pause && m_pre < tick_div) ? m_pre + 1 : 0;
            ld  = sw_load || (act && m_src && reload_pin && !m_pin);
            m_tc = 0;
            if (ld) begin
                m_cnt = m_img; m_pulse = 0; m_park = 0;
            end else if (!act) begin
                m_pulse = 0;
            end else if (tk) begin
                if (m_pulse) begin
                    m_pulse = 0;
                    if (m_src) m_park = 1; else m_cnt = m_img;
                end else if (!m_park) begin
                    if (m_cnt == (m_up ? 65535 : 0)) begin
                        m_pulse = 1; m_tc = 1;
                    end else begin
                        m_cnt = m_up ? (m_cnt + 1) % 65536 : m_cnt - 1;
                    end
                end
            end
            if (cmd_we && cmd_wdata[4] == 0 && cmd_wdata[2] == 0 && cmd_wdata[0] == 0) begin
                m_en = cmd_wdata[7]; m_pause = cmd_wdata[6]; m_src = cmd_wdata[5];
                m_pol = cmd_wdata[3]; m_up = cmd_wdata[1];
            end
            if (image_we) m_img = image_wdata;
            m_pin = reload_pin;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit exp_out;
        exp_out = m_pol ? m_pulse : !m_pulse;
        chk(count_val == m_cnt[15:0], cur_req, "count_val", count_val, m_cnt);
        chk(step_out == exp_out, cur_req, "step_out", step_out, exp_out);
        chk(tc_pulse == m_tc, cur_req, "tc_pulse", tc_pulse, m_tc);
    endtask

    // Advance one clock, sample a quarter period later, compare with model.
    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #(CLK_P/4);
            compare();
            cmd_we = 0; image_we = 0; sw_load = 0;
        end
    endtask

    task automatic wr_cmd(input logic [7:0] v);
        cmd_we = 1; cmd_wdata = v; cyc();
    endtask

    task automatic wr_img(input logic [15:0] v);
        image_we = 1; image_wdata = v; cyc();
    endtask

    task automatic wait_tc();
        for (int i = 0; i < 200 && !tc_pulse; i++) cyc();
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P*3 + CLK_P/4);
        // R1 reset state
        chk(count_val == 0, "R1", "count_val", count_val, 0);
        chk(step_out == 1, "R1", "step_out", step_out, 1);
        chk(tc_pulse == 0, "R1", "tc_pulse", tc_pulse, 0);
        rst_n = 1;
        cyc(2);

        // R3 R5 R6: down count, internal reload, divider 0
        cur_req = "R3";
        wr_img(5);
        sw_load = 1; cyc();
        chk(count_val == 5, "R8", "count after load", count_val, 5);
        wr_cmd(8'h80); run = 1;
        cyc(30);
        cur_req = "R6";
        cyc(20);

        // R2: divider 2
        cur_req = "R2";
        tick_div = 2;
        cyc(45);

        // R7: shadow write landing on the reload edge
        cur_req = "R7";
        tick_div = 0;
        wait_tc();
        image_we = 1; image_wdata = 9;
        cyc();
        chk(count_val == 5, "R7", "reload used old shadow", count_val, 5);
        wait_tc();
        cyc();
        chk(count_val == 9, "R7", "next reload uses new shadow", count_val, 9);

        // R4: inverted polarity
        cur_req = "R4";
        wr_cmd(8'h88);
        cyc(25);

        // R10: pause
        cur_req = "R10";
        wr_cmd(8'hC8);
        cyc(12);
        wr_cmd(8'h88);
        cyc(10);

        // R9: idle via run and via enable
        cur_req = "R9";
        run = 0;
        cyc(12);
        run = 1;
        wr_cmd(8'h00);
        cyc(10);
        chk(step_out == 1 && tc_pulse == 0, "R9", "idle output", step_out, 1);

        // R13: refused command word (enable + polarity + reserved bit 0)
        cur_req = "R13";
        wr_cmd(8'h89);
        cyc(3);
        chk(step_out == 1, "R13", "step_out after refused write", step_out, 1);

        // R11: up mode near wrap
        cur_req = "R11";
        wr_img(16'hFFFB);
        sw_load = 1; cyc();
        wr_cmd(8'h82);
        cyc(30);

        // R12: pin reload source
        cur_req = "R12";
        wr_img(3);
        wr_cmd(8'hA0);
        sw_load = 1; cyc();
        cyc(15);
        chk(count_val == 0 && tc_pulse == 0, "R12", "parked at terminal", count_val, 0);
        reload_pin = 1; cyc();
        chk(count_val == 3, "R12", "pin edge load", count_val, 3);
        cyc(3);
        reload_pin = 0;
        cyc(12);

        // R8: software load mid-count with divider
        cur_req = "R8";
        tick_div = 3;
        wr_cmd(8'h80);
        wr_img(20);
        sw_load = 1; cyc();
        chk(count_val == 20, "R8", "sw load mid count", count_val, 20);
        cyc(20);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule